// File: doc/BRIEF.md
# Eight-Channel Down-Counting Timer Bank

A bank of independent down-counting timers behind a simple register bus. Each channel has its own control register and count register on a fixed eight-byte stride. A channel is started and stopped through an enable bit, and a two-bit mode field picks how it behaves when its count runs out. In free-running mode the counter wraps through the whole range, so software can read it and use it as a time base. In one-shot mode the channel fires once and then stops. In periodic mode it reloads and fires on every period.

Each channel drives its own interrupt line with a one-cycle pulse when it expires. The live count of any channel can be read back at any time, and a read takes one clock. Software typically loads the count while the channel is stopped and then writes the control register to start it.

Top module: `tmr_bank`

## Requirements
- R1: After reset every channel has enable 0, mode 0, live count 0 and reload 0, every interrupt line is low and the read data output is 0.
- R2: Channel t's control register is at byte address t*8 and its count register at t*8+4. A read of any address whose two low bits are not 00 returns 0, and a write to such an address changes no channel.
- R3: A write to a control register sets enable from data bit 0 and mode from data bits 5:4. Modes are 0 free-running, 1 one-shot, 2 periodic, and 3 behaves as free-running. A read of the control register returns enable in bit 0 and mode in bits 5:4 with all other bits 0. Writing 0 stops the channel.
- R4: A write to a count register loads the full 32-bit value into both the live counter and the reload value. A disabled channel holds its count.
- R5: An enabled channel decrements by one on every clock, starting with the first clock after the enabling write. A read (rd_en high for one clock) presents, after that clock, the value the register held just before it. rdata holds when rd_en is low.
- R6: In free-running mode the clock that takes the count from 1 to 0 pulses that channel's interrupt for one cycle, and the count then wraps from 0 to 0xFFFFFFFF and keeps running.
- R7: In one-shot mode the clock that takes the count from 1 to 0 pulses the interrupt for one cycle and clears the enable bit, and the count stays 0.
- R8: In periodic mode the clock on which the count is 1 loads the reload value instead and pulses the interrupt, so a reload value N gives a pulse every N clocks.
- R9: An enabled channel whose count is already 0 gives no pulse. In one-shot mode it clears enable. In periodic mode it loads the reload value.
- R10: Each interrupt line belongs to its own channel. Activity on one channel never pulses another channel's line.
- R11: A count write to a running channel takes priority over that clock's decrement, and the following expiry and every later period use the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for one clock |
| rd_en | input | 1 | Read strobe for one clock |
| addr | input | 6 | Byte address (channel in bits 5:3, count select in bit 2) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 8 | One interrupt pulse line per channel |

## Verification
A register write takes effect on the clock it is presented, so a channel enabled on clock E first decrements on clock E+1. A count loaded with N therefore fires one-shot or free-running on clock E+N, and the interrupt is visible in the cycle after that clock. A periodic channel with reload N pulses every N clocks. Read data is due one clock after rd_en and carries the pre-clock value. The bench drives on falling edges and samples on the following falling edge. It counts falling edges from the enabling write to the pulse and compares that number with N. The readback expectations for wrap and decrement follow the same one-clock offset.

// File: rtl/tmr_bank_pkg.sv
package tmr_bank_pkg;

    typedef enum logic [1:0] {
        MODE_FREE   = 2'd0,
        MODE_ONCE   = 2'd1,
        MODE_RELOAD = 2'd2,
        MODE_RSVD   = 2'd3
    } tmr_mode_e;

    localparam int CH_STRIDE_LOG2 = 3;   // eight bytes per channel
    localparam int EN_BIT         = 0;
    localparam int MODE_LSB       = 4;
    localparam int MODE_MSB       = 5;

endpackage

// File: rtl/tmr_bank_dec.sv
module tmr_bank_dec #(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 6,
    parameter int CH_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_CH-1:0] ctrl_we,
    output logic [NUM_CH-1:0] cnt_we,
    output logic [CH_W-1:0]   sel_ch,
    output logic              sel_cnt,
    output logic              aligned
);
    import tmr_bank_pkg::*;

    always_comb begin
        sel_ch  = addr[ADDR_W-1:CH_STRIDE_LOG2];
        sel_cnt = addr[2];
        aligned = (addr[1:0] == 2'b00);
        ctrl_we = '0;
        cnt_we  = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (wr_en && aligned && (sel_ch == CH_W'(i))) begin
                ctrl_we[i] = !sel_cnt;
                cnt_we[i]  = sel_cnt;
            end
        end
    end

    // R2: one write reaches at most one register
    p_single_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctrl_we, cnt_we}));

    // R2: misaligned writes hit nothing
    p_misaligned_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr[1:0] != 2'b00) |-> ({ctrl_we, cnt_we} == '0));

endmodule

// File: rtl/tmr_bank_chan.sv
module tmr_bank_chan #(
    parameter int CNT_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ctrl_we,
    input  logic                    cnt_we,
    input  logic [CNT_W-1:0]        wdata,
    output logic                    en,
    output tmr_bank_pkg::tmr_mode_e mode,
    output logic [CNT_W-1:0]        cnt,
    output logic                    irq
);
    import tmr_bank_pkg::*;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic             en;
        tmr_mode_e        mode;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rld;
        logic             irq;
    } chan_st_t;

    chan_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (cnt_we) begin
            st_d.cnt = wdata;
            st_d.rld = wdata;
        end else if (st_q.en) begin
            case (st_q.mode)
                MODE_ONCE: begin
                    if (st_q.cnt == '0) begin
                        st_d.en = 1'b0;
                    end else if (st_q.cnt == ONE) begin
                        st_d.cnt = '0;
                        st_d.en  = 1'b0;
                        st_d.irq = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt - ONE;
                    end
                end
                MODE_RELOAD: begin
                    if (st_q.cnt == '0) begin
                        st_d.cnt = st_q.rld;
                    end else if (st_q.cnt == ONE) begin
                        st_d.cnt = st_q.rld;
                        st_d.irq = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt - ONE;
                    end
                end
                default: begin
                    st_d.cnt = st_q.cnt - ONE;
                    st_d.irq = (st_q.cnt == ONE);
                end
            endcase
        end
        if (ctrl_we) begin
            st_d.en   = wdata[EN_BIT];
            st_d.mode = tmr_mode_e'(wdata[MODE_MSB:MODE_LSB]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en   = st_q.en;
    assign mode = st_q.mode;
    assign cnt  = st_q.cnt;
    assign irq  = st_q.irq;

    // R4: a count write lands in the live counter
    p_cnt_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> (cnt == $past(wdata)));

    // R4: a stopped channel holds its count
    p_hold_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !cnt_we) |=> $stable(cnt));

    // R7: one-shot expiry stops the channel with a pulse
    p_once_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode == MODE_ONCE && cnt == ONE && !cnt_we && !ctrl_we)
        |=> (!en && irq && cnt == '0));

    // R8: periodic expiry reloads with a pulse
    p_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode == MODE_RELOAD && cnt == ONE && !cnt_we)
        |=> (irq && cnt == $past(st_q.rld)));

    // R10: a pulse comes only from a channel that was running
    p_irq_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(en));

    // R6: the pulse lasts one cycle
    p_pulse_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !$past(cnt_we)) |=> !irq || cnt != '0);

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank #(
    parameter int NUM_CH = 8,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic [NUM_CH-1:0] irq
);
    import tmr_bank_pkg::*;

    localparam int CH_W = ADDR_W - CH_STRIDE_LOG2;

    logic [NUM_CH-1:0] ctrl_we, cnt_we;
    logic [CH_W-1:0]   sel_ch;
    logic              sel_cnt, aligned;
    logic [CNT_W-1:0]  ch_cnt  [NUM_CH];
    logic [CNT_W-1:0]  ch_ctrl [NUM_CH];
    logic [CNT_W-1:0]  rdata_d, rdata_q;

    tmr_bank_dec #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .CH_W   (CH_W)
    ) dec_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .ctrl_we (ctrl_we),
        .cnt_we  (cnt_we),
        .sel_ch  (sel_ch),
        .sel_cnt (sel_cnt),
        .aligned (aligned)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic      en;
        tmr_mode_e mode;

        tmr_bank_chan #(.CNT_W(CNT_W)) chan_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctrl_we (ctrl_we[g]),
            .cnt_we  (cnt_we[g]),
            .wdata   (wdata),
            .en      (en),
            .mode    (mode),
            .cnt     (ch_cnt[g]),
            .irq     (irq[g])
        );

        always_comb begin
            ch_ctrl[g]                   = '0;
            ch_ctrl[g][EN_BIT]           = en;
            ch_ctrl[g][MODE_MSB:MODE_LSB] = mode;
        end
    end

    always_comb begin
        rdata_d = rdata_q;
        if (rd_en) begin
            if (!aligned) begin
                rdata_d = '0;
            end else if (sel_cnt) begin
                rdata_d = ch_cnt[sel_ch];
            end else begin
                rdata_d = ch_ctrl[sel_ch];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata = rdata_q;

    // R5: read data holds between reads
    p_rdata_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    // R2: misaligned reads return zero
    p_misaligned_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr[1:0] != 2'b00) |=> (rdata == '0));

endmodule

// File: tb/tmr_bank_tb_top.sv
module tmr_bank_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  irq;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_bank dut_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .irq   (irq)
    );

    function automatic logic [5:0] a_ctl(int t);
        return 6'(t * 8);
    endfunction

    function automatic logic [5:0] a_cnt(int t);
        return 6'(t * 8 + 4);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // all tasks are entered and left just after a falling edge
    task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic bus_rd(input logic [5:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    // falling edges until channel t pulses, bounded
    task automatic wait_irq(input int t, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!irq[t] && n < 200);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check(irq == 8'h00, "R1 irq", 32'(irq), 0);
        check(rdata == 0, "R1 rdata", rdata, 0);
        bus_rd(a_cnt(7), v);
        check(v == 0, "R1 count", v, 0);
        bus_rd(a_ctl(3), v);
        check(v == 0, "R1 ctrl", v, 0);
    endtask

    task automatic t_map;
        logic [31:0] v;
        bus_wr(6'h02, 32'hFFFF_FFFF);
        bus_wr(6'h06, 32'h1234_5678);
        bus_rd(a_ctl(0), v);
        check(v == 0, "R2 misaligned write ctrl", v, 0);
        bus_rd(a_cnt(0), v);
        check(v == 0, "R2 misaligned write count", v, 0);
        bus_wr(a_cnt(0), 32'hA5A5_0001);
        bus_rd(6'h05, v);
        check(v == 0, "R2 misaligned read", v, 0);
        bus_rd(a_cnt(0), v);
        check(v == 32'hA5A5_0001, "R2 count offset", v, 32'hA5A5_0001);
    endtask

    task automatic t_hold;
        logic [31:0] v;
        bus_wr(a_cnt(5), 32'd50);
        repeat (10) @(negedge clk);
        bus_rd(a_cnt(5), v);
        check(v == 32'd50, "R4 disabled hold", v, 32'd50);
    endtask

    task automatic t_live;
        logic [31:0] v1, v2;
        bus_wr(a_cnt(4), 32'd100);
        bus_wr(a_ctl(4), 32'h01);
        bus_rd(a_cnt(4), v1);
        bus_rd(a_cnt(4), v2);
        check(v1 == 32'd100, "R5 first read", v1, 32'd100);
        check(v2 == 32'd99, "R5 decrement", v2, 32'd99);
        bus_wr(a_ctl(4), 32'h00);
        bus_rd(a_cnt(4), v1);
        repeat (5) @(negedge clk);
        bus_rd(a_cnt(4), v2);
        check(v1 == v2, "R3 stop by zero write", v2, v1);
    endtask

    task automatic t_free;
        int n;
        logic [31:0] v;
        bus_wr(a_cnt(1), 32'd3);
        bus_wr(a_ctl(1), 32'h01);
        wait_irq(1, n);
        check(n == 3, "R6 free expiry clocks", 32'(n), 3);
        bus_rd(a_cnt(1), v);
        check(v == 0, "R6 count at expiry", v, 0);
        check(irq[1] == 1'b0, "R6 pulse width", 32'(irq), 0);
        bus_rd(a_cnt(1), v);
        check(v == 32'hFFFF_FFFF, "R6 wrap", v, 32'hFFFF_FFFF);
        bus_wr(a_ctl(1), 32'h00);
    endtask

    task automatic t_once;
        int n;
        logic [31:0] v;
        bus_wr(a_cnt(2), 32'd5);
        bus_wr(a_ctl(2), 32'h11);
        wait_irq(2, n);
        check(n == 5, "R7 one-shot clocks", 32'(n), 5);
        check(irq == 8'b0000_0100, "R10 only own line", 32'(irq), 32'h04);
        @(negedge clk);
        check(irq[2] == 1'b0, "R7 one pulse", 32'(irq), 0);
        bus_rd(a_ctl(2), v);
        check(v == 32'h10, "R7 enable cleared", v, 32'h10);
        bus_rd(a_cnt(2), v);
        check(v == 0, "R7 count stays zero", v, 0);
    endtask

    task automatic t_periodic;
        int n;
        logic [31:0] v;
        bus_wr(a_cnt(3), 32'd4);
        bus_wr(a_ctl(3), 32'h21);
        wait_irq(3, n);
        check(n == 4, "R8 first period", 32'(n), 4);
        wait_irq(3, n);
        check(n == 4, "R8 second period", 32'(n), 4);
        bus_wr(a_cnt(3), 32'd10);
        wait_irq(3, n);
        check(n == 10, "R11 write over running count", 32'(n), 10);
        wait_irq(3, n);
        check(n == 10, "R11 new reload", 32'(n), 10);
        bus_wr(a_ctl(3), 32'h00);
        n = 0;
        repeat (15) begin
            @(negedge clk);
            if (irq[3]) n++;
        end
        check(n == 0, "R3 stopped channel silent", 32'(n), 0);
    endtask

    task automatic t_zero_start;
        int n;
        logic [31:0] v;
        bus_wr(a_cnt(6), 32'd0);
        bus_wr(a_ctl(6), 32'h11);
        n = 0;
        repeat (4) begin
            @(negedge clk);
            if (irq[6]) n++;
        end
        bus_rd(a_ctl(6), v);
        check(n == 0 && v == 32'h10, "R9 one-shot at zero", v, 32'h10);
        bus_wr(a_cnt(6), 32'd7);
        bus_wr(a_cnt(6), 32'd0);
        bus_wr(a_ctl(6), 32'h21);
        bus_rd(a_cnt(6), v);
        bus_rd(a_cnt(6), v);
        check(v == 0, "R9 periodic at zero reload", v, 0);
        check(irq[6] == 1'b0, "R9 no pulse", 32'(irq), 0);
        bus_wr(a_ctl(6), 32'hFF);
        bus_rd(a_ctl(6), v);
        check(v == 32'h31, "R3 readback fields", v, 32'h31);
        bus_wr(a_cnt(6), 32'd20);
        bus_rd(a_cnt(6), v);
        bus_rd(a_cnt(6), v);
        check(v == 32'd19, "R3 mode 3 runs free", v, 32'd19);
        bus_wr(a_ctl(6), 32'h00);
    endtask

    initial begin : watchdog
        while (cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=<20000", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_hold();
        t_live();
        t_free();
        t_once();
        t_periodic();
        t_zero_start();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule